// File: doc/BRIEF.md
# Flexible Refresh Scheduler

This block decides, one clock at a time, when an all-bank auto-refresh should be requested from the DRAM command arbiter. It does not simply fire a fixed-period timer. When traffic is waiting it can defer refreshes and build up a debt, then pay that debt back as a dense burst. When the memory is idle it can run ahead with refreshes issued back to back, then realign to the nominal grid and skip the slots it has already covered.

The refresh mode (1x, 2x or 4x fine granularity) divides the configured refresh interval. The same mode multiplies the defer limit and the run-ahead limit. All timing comes from configuration inputs counted in clock cycles. The arbiter acknowledges each request with a grant. The block does not check command timing or track bank state.

Top module: `refresh_sched`

## Requirements
- R1: `cfg_mode` accepts 1, 2 or 4. Any other value sets `cfg_err` one clock later and the block behaves as in mode 1. A legal value clears `cfg_err` one clock later.
- R2: With both limits at zero, a refresh is requested once every effective interval. The effective interval is `cfg_trefi` shifted right by 0, 1 or 2 for modes 1, 2 and 4.
- R3: The defer limit is `cfg_max_postpone` times the mode value. The run-ahead limit is `cfg_max_pullin` times the mode value.
- R4: In the nominal state, pending traffic below the defer limit moves the block to deferring with no wait. Each further decision made while deferral is still allowed adds one to the debt and waits one interval; no refresh is issued. The debt is zero whenever the block is in the nominal state.
- R5: When deferral stops being allowed, a payback burst follows. The burst issues one refresh per debt unit, with `cfg_trfc` cycles between them. After the last one, realignment waits the interval minus `cfg_trfc` times (burst length − 1), and the block then returns to nominal.
- R6: In the nominal state, with no traffic pending and the debt below the run-ahead limit, the block starts running ahead. It issues back-to-back refreshes `cfg_trfc` cycles apart, adding one to the debt each time. This stops when traffic arrives or the limit is reached.
- R7: After running ahead, realignment waits the interval minus `cfg_trfc` times the refreshes issued. Skip slots follow: each waits one interval, issues no refresh and removes one debt unit. At zero debt the block returns to nominal.
- R8: `force_burst` high makes deferral allowed up to the defer limit whatever `req_pending` is, so a full-size burst always builds up.
- R9: `ref_req` stays high until a clock in which `ref_grant` is high. While it waits, the interval timer does not advance.
- R10: A one-cycle `reinit` pulse returns the block to nominal with zero debt and drops any request. The next decision is placed exactly one effective interval after that clock. Reset does the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reinit | input | 1 | Restart the schedule one interval from now |
| req_pending | input | 1 | Memory traffic is waiting |
| force_burst | input | 1 | Always defer up to the defer limit |
| cfg_mode | input | 3 | Refresh mode: 1, 2 or 4 |
| cfg_trefi | input | TW (16) | Nominal refresh interval in cycles |
| cfg_trfc | input | TW (16) | Refresh cycle time in cycles |
| cfg_max_postpone | input | CW (6) | Defer limit before mode scaling |
| cfg_max_pullin | input | CW (6) | Run-ahead limit before mode scaling |
| ref_grant | input | 1 | Arbiter accepts the pending refresh |
| ref_req | output | 1 | Refresh request, held until granted |
| cfg_err | output | 1 | Illegal refresh mode |

## Verification
The bound checker watches these rules on every cycle:
- the debt is zero in the nominal state;
- the debt stays within the scaled limit while deferring or running ahead;
- a request is never dropped without a grant;
- the timer is frozen while a request waits;
- skip slots never raise a request;
- the mode error flag follows the mode input.

Only the bench scenarios can show the exact clock on which each refresh appears. Those clocks reveal interval scaling per mode, burst length under the scaled defer limit, the realignment arithmetic after bursts and run-ahead, the effect of forced deferral, and the schedule shift caused by a late grant.

// File: rtl/refsched_pkg.sv
// Shared types and helpers for the flexible refresh scheduler.
// Assumes the mode input is a small integer; only 1, 2 and 4 are legal.
package refsched_pkg;

    typedef enum logic [2:0] {
        RS_NOMINAL = 3'd0,
        RS_DEFER   = 3'd1,
        RS_PAYBACK = 3'd2,
        RS_AHEAD   = 3'd3,
        RS_REALIGN = 3'd4,
        RS_SKIP    = 3'd5
    } rs_state_e;

    // Log2 of the mode value; illegal modes fall back to mode 1.
    function automatic logic [1:0] mode_shift(input logic [2:0] mode);
        case (mode)
            3'd2:    mode_shift = 2'd1;
            3'd4:    mode_shift = 2'd2;
            default: mode_shift = 2'd0;
        endcase
    endfunction

    function automatic logic mode_legal(input logic [2:0] mode);
        mode_legal = (mode == 3'd1) || (mode == 3'd2) || (mode == 3'd4);
    endfunction

endpackage

// File: rtl/refsched_cfg.sv
// Derives the effective interval and the scaled limits from the raw
// configuration. Purely combinational; assumes inputs are quasi-static.
module refsched_cfg
    import refsched_pkg::*;
#(
    parameter int TW = 16,
    parameter int CW = 6,
    localparam int DW = CW + 2
) (
    input  logic [2:0]    mode,
    input  logic [TW-1:0] trefi,
    input  logic [CW-1:0] max_pp,
    input  logic [CW-1:0] max_pi,
    output logic [TW-1:0] interval,
    output logic [DW-1:0] pp_lim,
    output logic [DW-1:0] pi_lim,
    output logic          mode_bad
);

    logic [1:0] shamt;

    // Scale interval down and limits up by the mode value.
    always_comb begin
        shamt    = mode_shift(mode);
        interval = trefi >> shamt;
        pp_lim   = DW'(max_pp) << shamt;
        pi_lim   = DW'(max_pi) << shamt;
        mode_bad = !mode_legal(mode);
    end

endmodule

// File: rtl/refsched_timer.sv
// Countdown between scheduling decisions. A decision fires when the count
// is zero and no request is waiting for its grant. A wait of W cycles
// places the next decision W clocks later (a wait of 0 means next clock).
// Assumes the restart value is stable while reset is held.
module refsched_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [TW-1:0] restart_wait,
    input  logic          hold,
    input  logic [TW-1:0] next_wait,
    output logic          fire,
    output logic [TW-1:0] count
);

    logic [TW-1:0] restart_load;
    logic [TW-1:0] next_load;

    // Convert a wait in cycles into a count load value.
    always_comb begin
        restart_load = (restart_wait == '0) ? '0 : restart_wait - 1'b1;
        next_load    = (next_wait == '0)    ? '0 : next_wait - 1'b1;
        fire         = (count == '0) && !hold && !restart;
    end

    // Load, reload on decision, or count down while not frozen.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count <= restart_load;
        end else if (fire) begin
            count <= next_load;
        end else if (!hold && count != '0) begin
            count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/refsched_fsm.sv
// Decision state machine: defer, payback burst, run-ahead, realign, skip.
// Acts only on timer decisions; owns the debt counter, the latched burst
// or run-ahead length, and the held refresh request.
// Assumes trfc >= 2 so back-to-back requests are separated by a low cycle.
module refsched_fsm
    import refsched_pkg::*;
#(
    parameter int TW = 16,
    parameter int CW = 6,
    localparam int DW = CW + 2,
    localparam int PW = TW + DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          fire,
    input  logic          pending,
    input  logic          force_max,
    input  logic          grant,
    input  logic [TW-1:0] interval,
    input  logic [TW-1:0] trfc,
    input  logic [DW-1:0] pp_lim,
    input  logic [DW-1:0] pi_lim,
    output logic [TW-1:0] wait_val,
    output logic          ref_req,
    output rs_state_e     state,
    output logic [DW-1:0] debt
);

    rs_state_e     state_n;
    logic [DW-1:0] debt_n;
    logic [DW-1:0] span;
    logic [DW-1:0] span_n;
    logic          from_ahead;
    logic          from_ahead_n;
    logic          issue;
    logic          may_defer;
    logic          may_ahead;
    logic [DW-1:0] align_mult;
    logic [PW-1:0] align_cut;
    logic [TW-1:0] align_wait;

    // Permission terms and the realignment wait, saturated at zero.
    always_comb begin
        may_defer  = (pending || force_max) && (debt < pp_lim);
        may_ahead  = !pending && (debt < pi_lim);
        align_mult = from_ahead ? span : span - 1'b1;
        align_cut  = PW'(trfc) * PW'(align_mult);
        align_wait = (PW'(interval) > align_cut) ? TW'(PW'(interval) - align_cut) : '0;
    end

    // Next-state, debt and wait selection for one decision.
    always_comb begin
        state_n      = state;
        debt_n       = debt;
        span_n       = span;
        from_ahead_n = from_ahead;
        issue        = 1'b0;
        wait_val     = '0;
        case (state)
            RS_NOMINAL: begin
                if (may_defer) begin
                    state_n = RS_DEFER;
                end else if (may_ahead) begin
                    state_n = RS_AHEAD;
                    span_n  = '0;
                end else begin
                    issue    = 1'b1;
                    wait_val = interval;
                end
            end
            RS_DEFER: begin
                if (may_defer) begin
                    debt_n   = debt + 1'b1;
                    wait_val = interval;
                end else if (debt == '0) begin
                    state_n = RS_NOMINAL;
                end else begin
                    state_n = RS_PAYBACK;
                    span_n  = debt;
                end
            end
            RS_PAYBACK: begin
                issue  = 1'b1;
                debt_n = debt - 1'b1;
                if (debt == DW'(1)) begin
                    state_n      = RS_REALIGN;
                    from_ahead_n = 1'b0;
                end else begin
                    wait_val = trfc;
                end
            end
            RS_AHEAD: begin
                if (may_ahead) begin
                    issue    = 1'b1;
                    debt_n   = debt + 1'b1;
                    span_n   = debt + 1'b1;
                    wait_val = trfc;
                end else begin
                    state_n      = RS_REALIGN;
                    from_ahead_n = 1'b1;
                end
            end
            RS_REALIGN: begin
                wait_val = align_wait;
                state_n  = from_ahead ? RS_SKIP : RS_NOMINAL;
            end
            RS_SKIP: begin
                if (debt == '0) begin
                    state_n = RS_NOMINAL;
                end else begin
                    debt_n   = debt - 1'b1;
                    wait_val = interval;
                    if (debt == DW'(1)) begin
                        state_n = RS_NOMINAL;
                    end
                end
            end
            default: state_n = RS_NOMINAL;
        endcase
    end

    // State registers advance only on decisions; restart clears them.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            state      <= RS_NOMINAL;
            debt       <= '0;
            span       <= '0;
            from_ahead <= 1'b0;
        end else if (fire) begin
            state      <= state_n;
            debt       <= debt_n;
            span       <= span_n;
            from_ahead <= from_ahead_n;
        end
    end

    // Refresh request: set on an issuing decision, cleared by grant.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ref_req <= 1'b0;
        end else if (fire && issue) begin
            ref_req <= 1'b1;
        end else if (grant) begin
            ref_req <= 1'b0;
        end
    end

endmodule

// File: rtl/refresh_sched.sv
// Top of the flexible refresh scheduler: configuration scaling, decision
// timer and decision state machine. Assumes configuration changes only
// while reset or reinit is applied.
module refresh_sched
    import refsched_pkg::*;
#(
    parameter int TW = 16,
    parameter int CW = 6,
    localparam int DW = CW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reinit,
    input  logic          req_pending,
    input  logic          force_burst,
    input  logic [2:0]    cfg_mode,
    input  logic [TW-1:0] cfg_trefi,
    input  logic [TW-1:0] cfg_trfc,
    input  logic [CW-1:0] cfg_max_postpone,
    input  logic [CW-1:0] cfg_max_pullin,
    input  logic          ref_grant,
    output logic          ref_req,
    output logic          cfg_err
);

    logic [TW-1:0] eff_interval;
    logic [DW-1:0] pp_lim;
    logic [DW-1:0] pi_lim;
    logic          mode_bad;
    logic          tmr_fire;
    logic [TW-1:0] tmr_count;
    logic [TW-1:0] dec_wait;
    logic          req_hold;
    rs_state_e     fsm_state;
    logic [DW-1:0] fsm_debt;

    refsched_cfg #(.TW(TW), .CW(CW)) u_cfg (
        .mode     (cfg_mode),
        .trefi    (cfg_trefi),
        .max_pp   (cfg_max_postpone),
        .max_pi   (cfg_max_pullin),
        .interval (eff_interval),
        .pp_lim   (pp_lim),
        .pi_lim   (pi_lim),
        .mode_bad (mode_bad)
    );

    // Timer freezes while a request waits for its grant.
    always_comb req_hold = ref_req && !ref_grant;

    refsched_timer #(.TW(TW)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (reinit),
        .restart_wait (eff_interval),
        .hold         (req_hold),
        .next_wait    (dec_wait),
        .fire         (tmr_fire),
        .count        (tmr_count)
    );

    refsched_fsm #(.TW(TW), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (reinit),
        .fire      (tmr_fire),
        .pending   (req_pending),
        .force_max (force_burst),
        .grant     (ref_grant),
        .interval  (eff_interval),
        .trfc      (cfg_trfc),
        .pp_lim    (pp_lim),
        .pi_lim    (pi_lim),
        .wait_val  (dec_wait),
        .ref_req   (ref_req),
        .state     (fsm_state),
        .debt      (fsm_debt)
    );

    // Registered configuration error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= mode_bad;
        end
    end

endmodule

// File: rtl/refresh_sched_chk.sv
// Assertion checker for refresh_sched, attached by bind below.
module refresh_sched_chk
    import refsched_pkg::*;
#(
    parameter int TW = 16,
    parameter int CW = 6,
    localparam int DW = CW + 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reinit,
    input logic          ref_grant,
    input logic          ref_req,
    input logic [2:0]    cfg_mode,
    input logic          cfg_err,
    input rs_state_e     fsm_state,
    input logic [DW-1:0] fsm_debt,
    input logic [DW-1:0] pp_lim,
    input logic [DW-1:0] pi_lim,
    input logic          tmr_fire,
    input logic [TW-1:0] tmr_count
);

    AST_BAD_MODE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_legal(cfg_mode) |=> cfg_err); // R1
    AST_GOOD_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        mode_legal(cfg_mode) |=> !cfg_err); // R1
    AST_DEFER_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == RS_DEFER) |-> (fsm_debt <= pp_lim)); // R3
    AST_NOMINAL_NO_DEBT: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == RS_NOMINAL) |-> (fsm_debt == '0)); // R4
    AST_AHEAD_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == RS_AHEAD) |-> (fsm_debt <= pi_lim)); // R6
    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == RS_SKIP && tmr_fire && !reinit) |=> !ref_req); // R7
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_grant && !reinit) |=> ref_req); // R9
    AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_grant && !reinit) |=> $stable(tmr_count)); // R9

endmodule

bind refresh_sched refresh_sched_chk #(.TW(TW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reinit    (reinit),
    .ref_grant (ref_grant),
    .ref_req   (ref_req),
    .cfg_mode  (cfg_mode),
    .cfg_err   (cfg_err),
    .fsm_state (fsm_state),
    .fsm_debt  (fsm_debt),
    .pp_lim    (pp_lim),
    .pi_lim    (pi_lim),
    .tmr_fire  (tmr_fire),
    .tmr_count (tmr_count)
);

// File: tb/refresh_sched_tb.sv
// Scoreboard bench: scenario tasks push the expected clock index of each
// refresh request; a monitor pops and compares on every rising request.
module refresh_sched_tb;

    localparam int TW = 16;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reinit = 1'b0;
    logic          req_pending = 1'b0;
    logic          force_burst = 1'b0;
    logic [2:0]    cfg_mode = 3'd1;
    logic [TW-1:0] cfg_trefi = 16'd40;
    logic [TW-1:0] cfg_trfc = 16'd4;
    logic [CW-1:0] cfg_max_postpone = '0;
    logic [CW-1:0] cfg_max_pullin = '0;
    logic          ref_grant = 1'b1;
    logic          ref_req;
    logic          cfg_err;

    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    int    exp_q[$];
    string tag_q[$];
    logic  prev_req = 1'b0;

    refresh_sched #(.TW(TW), .CW(CW)) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .reinit           (reinit),
        .req_pending      (req_pending),
        .force_burst      (force_burst),
        .cfg_mode         (cfg_mode),
        .cfg_trefi        (cfg_trefi),
        .cfg_trfc         (cfg_trfc),
        .cfg_max_postpone (cfg_max_postpone),
        .cfg_max_pullin   (cfg_max_pullin),
        .ref_grant        (ref_grant),
        .ref_req          (ref_req),
        .cfg_err          (cfg_err)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_at(input int edge_idx, input string req);
        exp_q.push_back(edge_idx);
        tag_q.push_back(req);
    endtask

    // Monitor: compare each new request against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && ref_req && !prev_req) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected request", cyc, -1);
            end else begin
                automatic int    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(cyc == e, t, cyc, e);
            end
        end
        prev_req <= ref_req;
    end

    task automatic wait_edge(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Apply a configuration with a reinit pulse; returns the reinit edge.
    task automatic start_case(input logic [2:0] m, input int trefi, input int trfc,
                              input int pp, input int pi, input bit pend,
                              input bit frc, input bit gnt, output int x);
        @(negedge clk);
        cfg_mode         = m;
        cfg_trefi        = TW'(trefi);
        cfg_trfc         = TW'(trfc);
        cfg_max_postpone = CW'(pp);
        cfg_max_pullin   = CW'(pi);
        req_pending      = pend;
        force_burst      = frc;
        ref_grant        = gnt;
        reinit           = 1'b1;
        x                = cyc + 1;
        @(negedge clk);
        reinit = 1'b0;
    endtask

    task automatic end_case(input int last, input string req);
        wait_edge(last + 2);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        report();
    end

    initial begin
        int x;
        repeat (4) @(negedge clk);
        check(ref_req == 1'b0, "R10 reset ref_req", ref_req, 0);
        check(cfg_err == 1'b0, "R10 reset cfg_err", cfg_err, 0);
        rst_n = 1'b1;

        // R1: illegal and legal mode values
        @(negedge clk); cfg_mode = 3'd3;
        @(negedge clk); check(cfg_err == 1'b1, "R1 mode 3", cfg_err, 1);
        cfg_mode = 3'd0;
        @(negedge clk); check(cfg_err == 1'b1, "R1 mode 0", cfg_err, 1);
        cfg_mode = 3'd4;
        @(negedge clk); check(cfg_err == 1'b0, "R1 mode 4", cfg_err, 0);

        // R2/R10: mode 1, interval 40, first request one interval after reinit
        start_case(3'd1, 40, 4, 0, 0, 1'b0, 1'b0, 1'b1, x);
        expect_at(x + 40, "R10 first after reinit");
        expect_at(x + 80, "R2 mode1 interval");
        end_case(x + 80, "R2 mode1 drained");

        // R2: mode 2 halves the interval
        start_case(3'd2, 40, 4, 0, 0, 1'b0, 1'b0, 1'b1, x);
        expect_at(x + 20, "R2 mode2 first");
        expect_at(x + 40, "R2 mode2 second");
        expect_at(x + 60, "R2 mode2 third");
        end_case(x + 60, "R2 mode2 drained");

        // R6/R7: run ahead three, realign, skip, then traffic forces nominal
        start_case(3'd1, 40, 4, 0, 3, 1'b0, 1'b0, 1'b1, x);
        expect_at(x + 41, "R6 ahead 1");
        expect_at(x + 45, "R6 ahead 2");
        expect_at(x + 49, "R6 ahead 3 limit");
        expect_at(x + 202, "R7 realign and skip");
        expect_at(x + 242, "R7 nominal resumes");
        wait_edge(x + 99);
        req_pending = 1'b1;
        end_case(x + 242, "R7 drained");

        // R3/R4/R5: mode 2, limit 2 scales to 4 deferred, payback burst
        start_case(3'd2, 80, 4, 2, 0, 1'b1, 1'b0, 1'b1, x);
        expect_at(x + 202, "R3 R5 burst 1");
        expect_at(x + 206, "R5 burst 2");
        expect_at(x + 210, "R5 burst 3");
        expect_at(x + 214, "R3 burst 4 last");
        expect_at(x + 243, "R5 realign");
        expect_at(x + 283, "R4 nominal after realign");
        wait_edge(x + 204);
        req_pending = 1'b0;
        end_case(x + 283, "R4 drained");

        // R8: forced deferral with no traffic beats run-ahead
        start_case(3'd1, 40, 4, 1, 2, 1'b0, 1'b1, 1'b1, x);
        expect_at(x + 82, "R8 forced burst");
        expect_at(x + 165, "R8 forced burst again");
        end_case(x + 165, "R8 drained");
        force_burst = 1'b0;

        // R9: late grant holds the request and shifts the schedule (mode 4)
        start_case(3'd4, 40, 4, 0, 0, 1'b0, 1'b0, 1'b0, x);
        expect_at(x + 10, "R9 mode4 first");
        expect_at(x + 27, "R9 shifted by stall");
        wait_edge(x + 11);
        begin
            bit held = 1'b1;
            while (cyc < x + 17) begin
                if (!ref_req) held = 1'b0;
                @(negedge clk);
            end
            if (!ref_req) held = 1'b0;
            check(held, "R9 request held", held, 1);
        end
        ref_grant = 1'b1;
        @(negedge clk);
        check(ref_req == 1'b0, "R9 dropped after grant", ref_req, 0);
        end_case(x + 27, "R9 drained");

        report();
    end

endmodule